// File: doc/BRIEF.md
# Address-Uniqueness Memory Test Engine

This block is a hardware test controller that finds aliased locations in a 32-bit word memory. An alias is two byte addresses that decode to the same physical word. The engine first fills every word of a test region with a value computed from that word's own byte address. Only after the last write has been accepted does it read the region back and compare each word. If two addresses share storage, the later write overwrites the earlier one, and the first read of the overwritten address returns the wrong value. That read exposes the fault.

Software starts a run with a one-cycle `start` pulse and waits for the one-cycle `done` pulse. The `soak_mode` input selects between two kinds of run:

- **Full-range run.** The region spans a fixed base up to the supplied top of memory. When `ovr_en` is high, explicit bounds replace this range.
- **Soak run.** The run covers a window of bounded size. The window moves forward by one span on every soak run, so repeated runs sweep all of memory.

A fixed address hole is never touched. Two error inputs abort a run at once, and each one reports its own code.

Top module: `alias_scan_engine`

## Requirements
- R1: The word written to byte address A is A rotated left by two bit positions: bits [29:0] of A move to bits [31:2] and bits [31:30] move to bits [1:0].
- R2: Every word of the region is written in ascending byte address order with a stride of 4. All reads start only after the final write, and they also run in ascending order. Each memory request lies inside the active region.
- R3: A full-range run with `ovr_en` low covers byte addresses from `FULL_BASE` (default 0x0010_0000) up to, but excluding, `top_of_mem` rounded down to a word boundary.
- R4: A full-range run with `ovr_en` high covers `ovr_start` up to, but excluding, `ovr_end`, both rounded down to a word boundary. Soak runs ignore the override.
- R5: A soak run covers the window from its current offset W up to the smaller of W+`SOAK_SPAN` and the word-aligned `top_of_mem`. After each soak run, W advances by `SOAK_SPAN`. If W+`SOAK_SPAN` reaches or passes top of memory, W instead returns to `FULL_BASE`. Reset sets W to `FULL_BASE`.
- R6: No request is ever issued to a byte address in the range `HOLE_BASE` (default 0xA0000) up to, but excluding, `HOLE_LIMIT` (default 0xC0000), even when the region covers it.
- R7: If `bus_err` is high during a run, no request is presented in that cycle. On the next cycle `done` pulses with `status_code` 0x0402, and no further requests follow.
- R8: If `host_err` is high during a run, the run aborts in the same way with code 0x0403. When both error inputs are high together, code 0x0402 is reported.
- R9: On the first read whose data differs from the expected word, the run stops. `done` pulses with code 0x0300 and `scan_pass` low. `fail_addr` holds that byte address, `fail_expected` holds the expected word and `fail_actual` holds the read word.
- R10: A run with no miscompare and no error ends with `done` high for exactly one cycle, `status_code` 0x0000 and `scan_pass` high. The results hold until the next run ends.
- R11: A request holds its address, data and direction stable while `mem_req_ready` is low. Once a read is accepted, no further request is presented until `mem_rsp_valid` returns its data.
- R12: A `start` pulse that arrives while `busy` is high is ignored. The ongoing run finishes with its own region and only one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| soak_mode | input | 1 | 1 = moving soak window, 0 = full range |
| top_of_mem | input | 32 | Exclusive top byte address of fitted memory |
| ovr_en | input | 1 | Use override bounds in a full-range run |
| ovr_start | input | 32 | Override start byte address |
| ovr_end | input | 32 | Override exclusive end byte address |
| bus_err | input | 1 | Peripheral bus error, aborts with 0x0402 |
| host_err | input | 1 | Processor-side bus error, aborts with 0x0403 |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| scan_pass | output | 1 | Last run passed |
| status_code | output | 16 | Last run result code |
| fail_addr | output | 32 | Failing byte address |
| fail_expected | output | 32 | Expected word at the failure |
| fail_actual | output | 32 | Word actually read |

## Verification
The bench runs against a memory model in which one address bit can be ignored. This fault makes the later write of a pair overwrite the earlier word. A design that started reading before the region was fully written, or that used the wrong rotation, would report the wrong failing address or the wrong word pair.

Regions that begin inside the hole or span it are checked for zero hole accesses and for exact word counts. An off-by-one hole limit would show up as extra or missing accesses.

Soak runs are repeated until the window wraps, including a top of memory that cuts a window short. A design that let the offset pass the top would issue requests beyond it.

Error inputs are raised during the write phase and during the read phase. A slow abort would let one more request through or deliver `done` late.

// File: rtl/alias_scan_pkg.sv
package alias_scan_pkg;

  localparam int SCAN_AW   = 32;
  localparam int ROT_BITS  = 2;
  localparam int CODE_W    = 16;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITE   = 2'd1,
    ST_RD_REQ  = 2'd2,
    ST_RD_WAIT = 2'd3
  } scan_state_t;

  localparam logic [CODE_W-1:0] CODE_PASS       = 16'h0000;
  localparam logic [CODE_W-1:0] CODE_MISCOMPARE = 16'h0300;
  localparam logic [CODE_W-1:0] CODE_BUS_ERR    = 16'h0402;
  localparam logic [CODE_W-1:0] CODE_HOST_ERR   = 16'h0403;

  // Test word for a byte address: left rotation by ROT_BITS.
  function automatic logic [SCAN_AW-1:0] addr_pattern(input logic [SCAN_AW-1:0] a);
    return (a << ROT_BITS) | (a >> (SCAN_AW - ROT_BITS));
  endfunction

  // Clear the byte-lane bits of an address held with one spare bit.
  function automatic logic [SCAN_AW:0] word_floor(input logic [SCAN_AW:0] a);
    return {a[SCAN_AW:2], 2'b00};
  endfunction

  // Move an address that lands in the reserved hole to the hole's end.
  function automatic logic [SCAN_AW:0] skip_hole(input logic [SCAN_AW:0] a,
                                                 input logic [SCAN_AW:0] hole_lo,
                                                 input logic [SCAN_AW:0] hole_hi);
    return (a >= hole_lo && a < hole_hi) ? hole_hi : a;
  endfunction

  function automatic logic [SCAN_AW:0] min_addr(input logic [SCAN_AW:0] a,
                                                input logic [SCAN_AW:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/alias_scan_region.sv
module alias_scan_region
  import alias_scan_pkg::*;
#(
  parameter logic [SCAN_AW-1:0] FULL_BASE = 32'h0010_0000,
  parameter logic [SCAN_AW-1:0] SOAK_SPAN = 32'h0400_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               soak_mode,
  input  logic [SCAN_AW-1:0] top_of_mem,
  input  logic               ovr_en,
  input  logic [SCAN_AW-1:0] ovr_start,
  input  logic [SCAN_AW-1:0] ovr_end,
  output logic [SCAN_AW:0]   region_lo,
  output logic [SCAN_AW:0]   region_hi
);

  localparam logic [SCAN_AW:0] BASE_X = {1'b0, FULL_BASE};
  localparam logic [SCAN_AW:0] SPAN_X = {1'b0, SOAK_SPAN};

  logic [SCAN_AW:0] win_q;
  logic [SCAN_AW:0] win_end;
  logic [SCAN_AW:0] win_next;
  logic [SCAN_AW:0] top_x;

  assign top_x    = word_floor({1'b0, top_of_mem});
  assign win_end  = win_q + SPAN_X;
  assign win_next = (win_end >= top_x) ? BASE_X : win_end;

  always_comb begin
    if (soak_mode) begin
      region_lo = win_q;
      region_hi = min_addr(win_end, top_x);
    end else if (ovr_en) begin
      region_lo = word_floor({1'b0, ovr_start});
      region_hi = word_floor({1'b0, ovr_end});
    end else begin
      region_lo = word_floor(BASE_X);
      region_hi = top_x;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       win_q <= BASE_X;
    else if (advance) win_q <= win_next;
  end

  // R5: a soak window never exceeds one span
  p_soak_span_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (soak_mode && region_hi > region_lo) |-> ((region_hi - region_lo) <= SPAN_X))
    else $error("soak window wider than span");

  // R5: the window offset moves only when a soak run is launched
  p_window_moves_on_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(win_q))
    else $error("soak offset moved without a run");

endmodule

// File: rtl/alias_scan_walker.sv
module alias_scan_walker
  import alias_scan_pkg::*;
#(
  parameter logic [SCAN_AW-1:0] HOLE_BASE  = 32'h000A_0000,
  parameter logic [SCAN_AW-1:0] HOLE_LIMIT = 32'h000C_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SCAN_AW:0] load_addr,
  input  logic             step,
  input  logic [SCAN_AW:0] limit,
  output logic [SCAN_AW:0] cur,
  output logic             at_end
);

  localparam logic [SCAN_AW:0] WORD_BYTES = (SCAN_AW+1)'(4);
  localparam logic [SCAN_AW:0] HOLE_LO_X  = {1'b0, HOLE_BASE};
  localparam logic [SCAN_AW:0] HOLE_HI_X  = {1'b0, HOLE_LIMIT};

  logic [SCAN_AW:0] cur_q;
  logic [SCAN_AW:0] cur_d;

  always_comb begin
    cur_d = cur_q;
    if (load)      cur_d = skip_hole(word_floor(load_addr), HOLE_LO_X, HOLE_HI_X);
    else if (step) cur_d = skip_hole(cur_q + WORD_BYTES, HOLE_LO_X, HOLE_HI_X);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign cur    = cur_q;
  assign at_end = (cur_q >= limit);

  // R2: each step moves forward by at least one word
  p_walk_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_q >= $past(cur_q) + WORD_BYTES))
    else $error("walker did not advance");

endmodule

// File: rtl/alias_scan_engine.sv
module alias_scan_engine
  import alias_scan_pkg::*;
#(
  parameter logic [SCAN_AW-1:0] FULL_BASE  = 32'h0010_0000,
  parameter logic [SCAN_AW-1:0] SOAK_SPAN  = 32'h0400_0000,
  parameter logic [SCAN_AW-1:0] HOLE_BASE  = 32'h000A_0000,
  parameter logic [SCAN_AW-1:0] HOLE_LIMIT = 32'h000C_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                soak_mode,
  input  logic [SCAN_AW-1:0]  top_of_mem,
  input  logic                ovr_en,
  input  logic [SCAN_AW-1:0]  ovr_start,
  input  logic [SCAN_AW-1:0]  ovr_end,
  input  logic                bus_err,
  input  logic                host_err,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_we,
  output logic [SCAN_AW-1:0]  mem_addr,
  output logic [SCAN_AW-1:0]  mem_wdata,
  input  logic                mem_rsp_valid,
  input  logic [SCAN_AW-1:0]  mem_rsp_data,
  output logic                busy,
  output logic                done,
  output logic                scan_pass,
  output logic [CODE_W-1:0]   status_code,
  output logic [SCAN_AW-1:0]  fail_addr,
  output logic [SCAN_AW-1:0]  fail_expected,
  output logic [SCAN_AW-1:0]  fail_actual
);

  scan_state_t state_q, state_d;

  logic [SCAN_AW:0] region_lo, region_hi;
  logic [SCAN_AW:0] lo_q, hi_q;
  logic [SCAN_AW:0] walk_cur;
  logic             walk_end;
  logic             walk_load, walk_step;
  logic [SCAN_AW:0] walk_load_addr;

  // named internal events
  logic             start_accept;
  logic             abort_evt;
  logic             req_fire;
  logic             miscompare_evt;
  logic             finish_evt;
  logic             fin_pass;
  logic [CODE_W-1:0] fin_code;
  logic [SCAN_AW-1:0] expected_word;

  logic               done_q, pass_q;
  logic [CODE_W-1:0]  code_q;
  logic [SCAN_AW-1:0] faddr_q, fexp_q, fact_q;

  alias_scan_region #(
    .FULL_BASE (FULL_BASE),
    .SOAK_SPAN (SOAK_SPAN)
  ) u_region (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (start_accept && soak_mode),
    .soak_mode  (soak_mode),
    .top_of_mem (top_of_mem),
    .ovr_en     (ovr_en),
    .ovr_start  (ovr_start),
    .ovr_end    (ovr_end),
    .region_lo  (region_lo),
    .region_hi  (region_hi)
  );

  alias_scan_walker #(
    .HOLE_BASE  (HOLE_BASE),
    .HOLE_LIMIT (HOLE_LIMIT)
  ) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (walk_load),
    .load_addr (walk_load_addr),
    .step      (walk_step),
    .limit     (hi_q),
    .cur       (walk_cur),
    .at_end    (walk_end)
  );

  assign busy          = (state_q != ST_IDLE);
  assign start_accept  = start && (state_q == ST_IDLE);
  assign abort_evt     = busy && (bus_err || host_err);
  assign mem_we        = (state_q == ST_WRITE);
  assign mem_req_valid = ((state_q == ST_WRITE) || (state_q == ST_RD_REQ))
                         && !walk_end && !bus_err && !host_err;
  assign mem_addr      = walk_cur[SCAN_AW-1:0];
  assign expected_word = addr_pattern(walk_cur[SCAN_AW-1:0]);
  assign mem_wdata     = expected_word;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign miscompare_evt = (state_q == ST_RD_WAIT) && mem_rsp_valid
                          && (mem_rsp_data != expected_word);

  assign walk_load      = start_accept || ((state_q == ST_WRITE) && walk_end);
  assign walk_load_addr = start_accept ? region_lo : lo_q;
  assign walk_step      = ((state_q == ST_WRITE) && req_fire)
                       || ((state_q == ST_RD_WAIT) && mem_rsp_valid && !miscompare_evt);

  always_comb begin
    state_d    = state_q;
    finish_evt = 1'b0;
    fin_pass   = 1'b0;
    fin_code   = CODE_PASS;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_WRITE;
      ST_WRITE:  if (walk_end) state_d = ST_RD_REQ;
      ST_RD_REQ: begin
        if (walk_end) begin
          state_d    = ST_IDLE;
          finish_evt = 1'b1;
          fin_pass   = 1'b1;
        end else if (req_fire) begin
          state_d = ST_RD_WAIT;
        end
      end
      ST_RD_WAIT: begin
        if (miscompare_evt) begin
          state_d    = ST_IDLE;
          finish_evt = 1'b1;
          fin_code   = CODE_MISCOMPARE;
        end else if (mem_rsp_valid) begin
          state_d = ST_RD_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_evt) begin
      state_d    = ST_IDLE;
      finish_evt = 1'b1;
      fin_pass   = 1'b0;
      fin_code   = bus_err ? CODE_BUS_ERR : CODE_HOST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (start_accept) begin
        lo_q <= region_lo;
        hi_q <= region_hi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      code_q  <= CODE_PASS;
      faddr_q <= '0;
      fexp_q  <= '0;
      fact_q  <= '0;
    end else begin
      done_q <= finish_evt;
      if (finish_evt) begin
        pass_q <= fin_pass;
        code_q <= fin_code;
        if (miscompare_evt && !abort_evt) begin
          faddr_q <= walk_cur[SCAN_AW-1:0];
          fexp_q  <= expected_word;
          fact_q  <= mem_rsp_data;
        end else begin
          faddr_q <= '0;
          fexp_q  <= '0;
          fact_q  <= '0;
        end
      end
    end
  end

  assign done          = done_q;
  assign scan_pass     = pass_q;
  assign status_code   = code_q;
  assign fail_addr     = faddr_q;
  assign fail_expected = fexp_q;
  assign fail_actual   = fact_q;

  // R6: the reserved hole is never addressed
  p_hole_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !(mem_addr >= HOLE_BASE && mem_addr < HOLE_LIMIT))
    else $error("request inside reserved hole");

  // R2: requests stay inside the latched region
  p_inside_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ({1'b0, mem_addr} >= lo_q && {1'b0, mem_addr} < hi_q))
    else $error("request outside region");

  // R11: a stalled request is held unless the run aborts
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (abort_evt || (mem_req_valid && $stable(mem_addr) && $stable(mem_we))))
    else $error("stalled request changed");

  // R7: an error presents no request in the cycle it is seen
  p_err_blocks_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err || host_err) |-> !mem_req_valid)
    else $error("request presented during error");

  // R7/R8: abort yields done with an error code next cycle
  p_abort_reports_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (done && !scan_pass && (status_code == CODE_BUS_ERR || status_code == CODE_HOST_ERR)))
    else $error("abort not reported");

  // R9: a miscompare ends the run with its code
  p_miscompare_reports_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miscompare_evt && !abort_evt) |=> (done && status_code == CODE_MISCOMPARE && !busy))
    else $error("miscompare not reported");

  // R10: done is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done held for more than a cycle");

endmodule

// File: tb/alias_scan_engine_tb.sv
module alias_scan_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TB_BASE   = 32'h100;
  localparam logic [31:0] TB_SPAN   = 32'h100;
  localparam logic [31:0] TB_HOLE_L = 32'h200;
  localparam logic [31:0] TB_HOLE_H = 32'h240;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, soak_mode = 1'b0, ovr_en = 1'b0;
  logic [31:0] top_of_mem = 32'h400, ovr_start = '0, ovr_end = '0;
  logic bus_err = 1'b0, host_err = 1'b0;
  logic mem_req_valid, mem_req_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic busy, done, scan_pass;
  logic [15:0] status_code;
  logic [31:0] fail_addr, fail_expected, fail_actual;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_scan_engine #(
    .FULL_BASE (TB_BASE), .SOAK_SPAN (TB_SPAN),
    .HOLE_BASE (TB_HOLE_L), .HOLE_LIMIT (TB_HOLE_H)
  ) u_dut (
    .clk, .rst_n, .start, .soak_mode, .top_of_mem, .ovr_en, .ovr_start, .ovr_end,
    .bus_err, .host_err, .mem_req_valid, .mem_req_ready, .mem_we, .mem_addr,
    .mem_wdata, .mem_rsp_valid, .mem_rsp_data, .busy, .done, .scan_pass,
    .status_code, .fail_addr, .fail_expected, .fail_actual
  );

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  // memory model with optional ignored address bits
  logic [31:0] mem_model [0:1023];
  logic [31:0] shadow    [0:1023];
  logic [31:0] alias_mask = '0;
  int wr_cnt, rd_cnt, acc_cnt, hole_hits, pat_errs, order_errs, done_cnt;
  logic [31:0] min_a, max_a;
  int ready_phase = 0;

  function automatic logic [31:0] rot_ref(input logic [31:0] a);
    return {a[29:0], a[31:30]};
  endfunction
  function automatic int idx_of(input logic [31:0] a, input logic [31:0] m);
    logic [31:0] t;
    t = a & ~m;
    return int'(t[11:2]);
  endfunction
  function automatic bit in_hole(input logic [31:0] a);
    return (a >= TB_HOLE_L) && (a < TB_HOLE_H);
  endfunction
  function automatic int words_in(input logic [31:0] lo, input logic [31:0] hi);
    int n = 0;
    for (logic [31:0] a = lo; a < hi; a += 4) if (!in_hole(a)) n++;
    return n;
  endfunction

  always @(negedge clk) begin
    mem_req_ready <= (ready_phase % 3) != 2;
    ready_phase++;
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (done) done_cnt++;
    if (mem_req_valid && mem_req_ready) begin
      acc_cnt++;
      if (in_hole(mem_addr)) hole_hits++;
      if (mem_addr < min_a) min_a = mem_addr;
      if (mem_addr > max_a) max_a = mem_addr;
      if (mem_we) begin
        mem_model[idx_of(mem_addr, alias_mask)] <= mem_wdata;
        wr_cnt++;
        if (rd_cnt != 0) order_errs++;
        if (mem_wdata != rot_ref(mem_addr)) pat_errs++;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_model[idx_of(mem_addr, alias_mask)];
        rd_cnt++;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG_CYCLES) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG_CYCLES);
        summary();
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; acc_cnt = 0; hole_hits = 0; pat_errs = 0;
    order_errs = 0; done_cnt = 0; min_a = 32'hFFFF_FFFF; max_a = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      if (done) return;
    end
  endtask

  // run and verify a clean pass over [lo,hi)
  task automatic run_clean(input string req, input logic [31:0] lo, input logic [31:0] hi);
    int n;
    logic [31:0] first, last;
    n = words_in(lo, hi);
    first = in_hole(lo) ? TB_HOLE_H : lo;
    last  = in_hole(hi - 4) ? TB_HOLE_L - 4 : hi - 4;
    clear_stats();
    pulse_start();
    wait_done();
    check({req, " done"}, done, 1'b1);
    check({req, " code R10"}, status_code, 16'h0000);
    check({req, " pass R10"}, scan_pass, 1'b1);
    check({req, " writes"}, wr_cnt, n);
    check({req, " reads R2"}, rd_cnt, n);
    check({req, " lowest"}, min_a, first);
    check({req, " highest"}, max_a, last);
    check({req, " hole R6"}, hole_hits, 0);
    check({req, " pattern R1"}, pat_errs, 0);
    check({req, " order R2"}, order_errs, 0);
    @(posedge clk); #1;
    check({req, " done pulse R10"}, done, 1'b0);
  endtask

  task automatic t_reset();
    check("R10 reset done", done, 1'b0);
    check("R10 reset busy", busy, 1'b0);
    check("R11 reset req", mem_req_valid, 1'b0);
    check("R10 reset code", status_code, 16'h0000);
  endtask

  task automatic t_full();
    soak_mode = 0; ovr_en = 0; top_of_mem = 32'h400;
    run_clean("R3 full", TB_BASE, 32'h400);
    top_of_mem = 32'h3F3;   // unaligned top rounds down
    run_clean("R3 full unaligned", TB_BASE, 32'h3F0);
    top_of_mem = 32'h400;
  endtask

  task automatic t_override();
    soak_mode = 0; ovr_en = 1;
    ovr_start = 32'h140; ovr_end = 32'h1C0;
    run_clean("R4 override", 32'h140, 32'h1C0);
    ovr_start = 32'h222; ovr_end = 32'h280;   // starts in hole
    run_clean("R4 R6 override in hole", 32'h220, 32'h280);
    ovr_en = 0;
  endtask

  task automatic t_soak();
    soak_mode = 1; top_of_mem = 32'h400;
    run_clean("R5 soak w0", 32'h100, 32'h200);
    run_clean("R5 soak w1", 32'h200, 32'h300);
    run_clean("R5 soak w2", 32'h300, 32'h400);
    run_clean("R5 soak wrap", 32'h100, 32'h200);
    top_of_mem = 32'h380;
    ovr_en = 1; ovr_start = 32'h340; ovr_end = 32'h360; // ignored in soak
    run_clean("R4 R5 soak w1b", 32'h200, 32'h300);
    run_clean("R5 soak cut", 32'h300, 32'h380);
    run_clean("R5 soak wrap2", 32'h100, 32'h200);
    ovr_en = 0; soak_mode = 0; top_of_mem = 32'h400;
  endtask

  task automatic t_alias();
    bit found;
    logic [31:0] fa, fe, fv;
    alias_mask = 32'h80;
    found = 0; fa = 0; fe = 0; fv = 0;
    for (logic [31:0] a = TB_BASE; a < 32'h400; a += 4)
      if (!in_hole(a)) shadow[idx_of(a, alias_mask)] = rot_ref(a);
    for (logic [31:0] a = TB_BASE; a < 32'h400; a += 4)
      if (!in_hole(a) && !found && shadow[idx_of(a, alias_mask)] != rot_ref(a)) begin
        found = 1; fa = a; fe = rot_ref(a); fv = shadow[idx_of(a, alias_mask)];
      end
    clear_stats();
    pulse_start();
    wait_done();
    check("R9 code", status_code, 16'h0300);
    check("R9 pass low", scan_pass, 1'b0);
    check("R9 fail addr", fail_addr, fa);
    check("R9 R1 expected", fail_expected, fe);
    check("R9 actual", fail_actual, fv);
    check("R9 stopped at first", rd_cnt, (fa - TB_BASE) / 4 + 1);
    alias_mask = '0;
  endtask

  task automatic t_abort(input string req, input bit b, input bit h,
                         input bit in_read, input logic [15:0] code);
    int snap;
    clear_stats();
    pulse_start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (in_read ? (rd_cnt >= 5) : (wr_cnt >= 10)) break;
    end
    bus_err = b; host_err = h;
    snap = acc_cnt;
    @(posedge clk); #1;
    check({req, " done next cycle"}, done, 1'b1);
    check({req, " code"}, status_code, code);
    @(negedge clk) begin bus_err = 0; host_err = 0; end
    repeat (20) @(negedge clk);
    check({req, " no more requests"}, acc_cnt, snap);
    check({req, " idle"}, busy, 1'b0);
  endtask

  task automatic t_start_busy();
    int n;
    n = words_in(TB_BASE, 32'h400);
    clear_stats();
    pulse_start();
    repeat (30) @(negedge clk);
    ovr_en = 1; ovr_start = 32'h300; ovr_end = 32'h310;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);
    check("R12 writes unchanged", wr_cnt, n);
    check("R12 single done", done_cnt, 1);
    check("R12 code", status_code, 16'h0000);
    ovr_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem_model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_override();
    t_soak();
    t_alias();
    t_abort("R7 bus err write", 1, 0, 0, 16'h0402);
    t_abort("R8 host err read", 0, 1, 1, 16'h0403);
    t_abort("R8 both errs", 1, 1, 0, 16'h0402);
    run_clean("R10 after abort", TB_BASE, 32'h400);
    t_start_busy();
    summary();
  end

endmodule